// File: doc/BRIEF.md
# I2C Register Target with 16-bit Register Addresses

This block is the target end of a two-wire serial control bus. A host reaches an internal register file of 8-bit registers, each with its own 16-bit address. The block oversamples both bus lines with the system clock and finds the start, repeated-start and stop conditions. It answers only to its own device address. It then takes a two-byte register address, high byte first, and either commits one data byte or returns one data byte. Toward the register file it presents a plain address, write-data, write-strobe and read-data port.

A write sequence is: start, device byte 0x64, high address byte, low address byte, data byte, stop. The target acknowledges every byte. A read sequence sends the same device byte and both address bytes. It then issues a repeated start with device byte 0x65 and clocks in one byte from the stored address. The two lowest register addresses hold a fixed identification pair. This pair is served inside the block and cannot be overwritten.

The target never drives the data line high. It has one output, a pull-low enable, and the pad holds SDA low while that enable is set.

Top module: `i2cr_regslave`

## Requirements
- R1: After reset, sda_oe is 0 and reg_we is 0.
- R2: SDA falling while SCL is high is a start and restarts device-byte decoding, even in the middle of a transfer. SDA rising while SCL is high is a stop and returns the target to idle.
- R3: A device byte whose upper seven bits equal 0x32 is acknowledged. Bit 0 of that byte selects the direction, with 0 meaning write and 1 meaning read.
- R4: A device byte with any other address is not acknowledged. The target then ignores the bus and drives nothing until the next start or stop.
- R5: The two bytes after a write device byte are taken as the register address, high byte first. Each is acknowledged, and reg_addr shows {high, low}.
- R6: The byte after the low address byte is acknowledged and written. It appears on reg_wdata with a one-cycle reg_we pulse on the SCL falling edge that ends its eighth bit.
- R7: After a repeated start with device byte 0x65, the target returns the byte at the stored address on SDA, most significant bit first.
- R8: A read device byte is not acknowledged unless a full register address was received since the last stop.
- R9: Address 0x0000 reads 0x08 and address 0x0001 reads 0x06. Writes to these two addresses are acknowledged but never raise reg_we.
- R10: After the returned data byte the target releases SDA for the acknowledge bit. It then drives nothing until the next start or stop, whatever the master answers.
- R11: sda_oe only rises while SCL is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock used to oversample the bus |
| rst | input | 1 | Synchronous reset, active high |
| scl_i | input | 1 | SCL line level |
| sda_i | input | 1 | SDA line level (wired-AND of all drivers) |
| sda_oe | output | 1 | Pull SDA low when 1 |
| reg_addr | output | 16 | Register address toward the register file |
| reg_wdata | output | 8 | Data byte to be written |
| reg_we | output | 1 | One-cycle write strobe |
| reg_rdata | input | 8 | Read data from the register file at reg_addr |

## Verification
A bit counter that slips, or a byte phase that is wrong, shows up at the next acknowledge slot. An acknowledge goes missing or an extra one appears, or the register address gets bytes in the wrong order. Each of these is visible within nine SCL periods. A direction flag or address-valid flag that is wrong leaves SDA driven after the read byte, or lets a read go through with no address, so a stuck target shows up as SDA held low after a stop. Writes that reach the identification pair, or strobes that come twice, show at reg_we in the same cycle they happen.

// File: rtl/i2cr_pkg.sv
package i2cr_pkg;

    localparam int BYTE_W  = 8;
    localparam int ADDR_W  = 16;
    localparam int BITCNT_W = 4;

    localparam logic [6:0]        DEV_ID7   = 7'h32;
    localparam logic [BYTE_W-1:0] ID_HI_VAL = 8'h08;
    localparam logic [BYTE_W-1:0] ID_LO_VAL = 8'h06;

    typedef enum logic [3:0] {
        PH_IDLE,
        PH_DEV,
        PH_ACK_DEV,
        PH_AHI,
        PH_ACK_AHI,
        PH_ALO,
        PH_ACK_ALO,
        PH_WDAT,
        PH_ACK_WD,
        PH_TX,
        PH_RACK,
        PH_HOLD
    } phase_t;

    function automatic logic is_id_addr(input logic [ADDR_W-1:0] a);
        return a[ADDR_W-1:1] == '0;
    endfunction

    function automatic logic [BYTE_W-1:0] id_value(input logic [ADDR_W-1:0] a);
        return a[0] ? ID_LO_VAL : ID_HI_VAL;
    endfunction

endpackage

// File: rtl/i2cr_linesync.sv
module i2cr_linesync #(
    parameter int LINES  = 2,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [LINES-1:0] din,
    output logic [LINES-1:0] level,
    output logic [LINES-1:0] rise,
    output logic [LINES-1:0] fall
);
    for (genvar g = 0; g < LINES; g++) begin : g_line
        logic [STAGES:0] pipe;
        always_ff @(posedge clk) begin
            if (rst) pipe <= '1;
            else     pipe <= {pipe[STAGES-1:0], din[g]};
        end
        assign level[g] = pipe[STAGES-1];
        assign rise[g]  =  pipe[STAGES-1] & ~pipe[STAGES];
        assign fall[g]  = ~pipe[STAGES-1] &  pipe[STAGES];
    end
endmodule

// File: rtl/i2cr_ctrl.sv
module i2cr_ctrl
    import i2cr_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              scl_rise,
    input  logic              scl_fall,
    input  logic              sda_lvl,
    input  logic              start_det,
    input  logic              stop_det,
    input  logic [BYTE_W-1:0] rd_byte,
    output logic              sda_oe,
    output logic [ADDR_W-1:0] addr,
    output logic [BYTE_W-1:0] wdata,
    output logic              wr_req
);
    phase_t              ph;
    logic [BITCNT_W-1:0] cnt;
    logic [BYTE_W-1:0]   rx_sh;
    logic [BYTE_W-1:0]   tx_sh;
    logic [BYTE_W-1:0]   a_hi, a_lo;
    logic                rd_mode;
    logic                addr_ok;
    logic                rx_phase;
    logic                byte_done;
    logic                dev_match;

    assign addr      = {a_hi, a_lo};
    assign rx_phase  = (ph == PH_DEV) || (ph == PH_AHI) || (ph == PH_ALO) || (ph == PH_WDAT);
    assign byte_done = rx_phase && scl_fall && (cnt == 4'd8);
    assign dev_match = (rx_sh[7:1] == DEV_ID7) && (!rx_sh[0] || addr_ok);

    always_ff @(posedge clk) begin
        if (rst) begin
            ph      <= PH_IDLE;
            cnt     <= '0;
            rx_sh   <= '0;
            tx_sh   <= '0;
            a_hi    <= '0;
            a_lo    <= '0;
            wdata   <= '0;
            wr_req  <= 1'b0;
            sda_oe  <= 1'b0;
            rd_mode <= 1'b0;
            addr_ok <= 1'b0;
        end else begin
            wr_req <= 1'b0;
            if (stop_det) begin
                ph      <= PH_IDLE;
                cnt     <= '0;
                sda_oe  <= 1'b0;
                addr_ok <= 1'b0;
            end else if (start_det) begin
                ph     <= PH_DEV;
                cnt    <= '0;
                sda_oe <= 1'b0;
            end else if (rx_phase && scl_rise && cnt != 4'd8) begin
                rx_sh <= {rx_sh[6:0], sda_lvl};
                cnt   <= cnt + 4'd1;
            end else if (byte_done) begin
                cnt <= '0;
                case (ph)
                    PH_DEV: begin
                        if (dev_match) begin
                            sda_oe  <= 1'b1;
                            rd_mode <= rx_sh[0];
                            ph      <= PH_ACK_DEV;
                        end else begin
                            ph <= PH_HOLD;
                        end
                    end
                    PH_AHI: begin
                        a_hi   <= rx_sh;
                        sda_oe <= 1'b1;
                        ph     <= PH_ACK_AHI;
                    end
                    PH_ALO: begin
                        a_lo    <= rx_sh;
                        addr_ok <= 1'b1;
                        sda_oe  <= 1'b1;
                        ph      <= PH_ACK_ALO;
                    end
                    default: begin
                        wdata  <= rx_sh;
                        wr_req <= 1'b1;
                        sda_oe <= 1'b1;
                        ph     <= PH_ACK_WD;
                    end
                endcase
            end else if (scl_fall) begin
                case (ph)
                    PH_ACK_DEV: begin
                        if (rd_mode) begin
                            tx_sh  <= rd_byte;
                            sda_oe <= ~rd_byte[7];
                            cnt    <= '0;
                            ph     <= PH_TX;
                        end else begin
                            sda_oe <= 1'b0;
                            ph     <= PH_AHI;
                        end
                    end
                    PH_ACK_AHI: begin
                        sda_oe <= 1'b0;
                        ph     <= PH_ALO;
                    end
                    PH_ACK_ALO: begin
                        sda_oe <= 1'b0;
                        ph     <= PH_WDAT;
                    end
                    PH_ACK_WD: begin
                        sda_oe <= 1'b0;
                        ph     <= PH_HOLD;
                    end
                    PH_TX: begin
                        if (cnt == 4'd7) begin
                            sda_oe <= 1'b0;
                            ph     <= PH_RACK;
                        end else begin
                            cnt    <= cnt + 4'd1;
                            tx_sh  <= {tx_sh[6:0], 1'b0};
                            sda_oe <= ~tx_sh[6];
                        end
                    end
                    default: ;
                endcase
            end else if (scl_rise && ph == PH_RACK) begin
                ph <= PH_HOLD;
            end
        end
    end
endmodule

// File: rtl/i2cr_regslave.sv
module i2cr_regslave
    import i2cr_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              scl_i,
    input  logic              sda_i,
    output logic              sda_oe,
    output logic [ADDR_W-1:0] reg_addr,
    output logic [BYTE_W-1:0] reg_wdata,
    output logic              reg_we,
    input  logic [BYTE_W-1:0] reg_rdata
);
    localparam int LN_SCL = 0;
    localparam int LN_SDA = 1;

    logic [1:0] lvl, rise, fall;
    logic       start_det, stop_det;
    logic       wr_req;
    logic [BYTE_W-1:0] rd_byte;

    i2cr_linesync #(.LINES(2), .STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst   (rst),
        .din   ({sda_i, scl_i}),
        .level (lvl),
        .rise  (rise),
        .fall  (fall)
    );

    assign start_det = fall[LN_SDA] & lvl[LN_SCL];
    assign stop_det  = rise[LN_SDA] & lvl[LN_SCL];

    assign rd_byte = is_id_addr(reg_addr) ? id_value(reg_addr) : reg_rdata;
    assign reg_we  = wr_req & ~is_id_addr(reg_addr);

    i2cr_ctrl u_ctrl (
        .clk       (clk),
        .rst       (rst),
        .scl_rise  (rise[LN_SCL]),
        .scl_fall  (fall[LN_SCL]),
        .sda_lvl   (lvl[LN_SDA]),
        .start_det (start_det),
        .stop_det  (stop_det),
        .rd_byte   (rd_byte),
        .sda_oe    (sda_oe),
        .addr      (reg_addr),
        .wdata     (reg_wdata),
        .wr_req    (wr_req)
    );
endmodule

// File: rtl/i2cr_regslave_chk.sv
module i2cr_regslave_chk (
    input logic        clk,
    input logic        rst,
    input logic        scl_i,
    input logic        sda_oe,
    input logic        reg_we,
    input logic [15:0] reg_addr
);
    // R1
    reset_release_chk: assert property (@(posedge clk)
        $past(rst) |-> (!sda_oe && !reg_we));

    // R9
    id_write_block_chk: assert property (@(posedge clk) disable iff (rst)
        reg_we |-> (reg_addr[15:1] != 15'd0));

    // R6
    we_single_chk: assert property (@(posedge clk) disable iff (rst)
        reg_we |=> !reg_we);

    // R6
    we_scl_low_chk: assert property (@(posedge clk) disable iff (rst)
        reg_we |-> !scl_i);

    // R11
    oe_rise_scl_low_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(sda_oe) |-> !scl_i);
endmodule

bind i2cr_regslave i2cr_regslave_chk u_chk (
    .clk      (clk),
    .rst      (rst),
    .scl_i    (scl_i),
    .sda_oe   (sda_oe),
    .reg_we   (reg_we),
    .reg_addr (reg_addr)
);

// File: tb/i2cr_regslave_test.sv
module i2cr_regslave_test;
    localparam int Q = 10;

    typedef struct packed {
        logic        wr;
        logic [15:0] a;
        logic [7:0]  d;
    } vec_t;

    localparam vec_t VECS [14] = '{
        '{1'b1, 16'h0013, 8'hA5},
        '{1'b0, 16'h0013, 8'hA5},
        '{1'b1, 16'h7F05, 8'h3C},
        '{1'b0, 16'h7F05, 8'h3C},
        '{1'b0, 16'h0000, 8'h08},
        '{1'b0, 16'h0001, 8'h06},
        '{1'b1, 16'h0000, 8'hFF},
        '{1'b0, 16'h0000, 8'h08},
        '{1'b1, 16'h0001, 8'h00},
        '{1'b0, 16'h0001, 8'h06},
        '{1'b0, 16'h0102, 8'h25},
        '{1'b0, 16'hAB0C, 8'hCF},
        '{1'b1, 16'hFFFF, 8'h81},
        '{1'b0, 16'hFFFF, 8'h81}
    };

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        scl_m = 1'b1;
    logic        sda_m = 1'b1;
    logic        sda_line;
    logic        sda_oe;
    logic [15:0] reg_addr;
    logic [7:0]  reg_wdata;
    logic        reg_we;
    logic [7:0]  reg_rdata;
    logic [7:0]  mem [16];
    int          wcount;
    int          n_chk = 0;
    int          n_bad = 0;
    int          oe_viol = 0;
    logic        oe_prev = 1'b0;
    logic        done = 1'b0;

    always #5 clk = ~clk;

    assign sda_line  = sda_m & ~sda_oe;
    assign reg_rdata = mem[reg_addr[3:0]];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < 16; i++) mem[i] <= 8'(i * 17 + 3);
            wcount <= 0;
        end else if (reg_we) begin
            mem[reg_addr[3:0]] <= reg_wdata;
            wcount <= wcount + 1;
        end
    end

    // R11 monitor: count pull-low starts while SCL is high
    always @(negedge clk) begin
        if (!rst && sda_oe && !oe_prev && scl_m) oe_viol++;
        oe_prev <= sda_oe;
    end

    i2cr_regslave uut (
        .clk       (clk),
        .rst       (rst),
        .scl_i     (scl_m),
        .sda_i     (sda_line),
        .sda_oe    (sda_oe),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .reg_we    (reg_we),
        .reg_rdata (reg_rdata)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic hq();
        repeat (Q) @(negedge clk);
    endtask

    task automatic bus_start();
        sda_m = 1'b1; hq();
        scl_m = 1'b1; hq();
        sda_m = 1'b0; hq();
        scl_m = 1'b0; hq();
    endtask

    task automatic bus_stop();
        sda_m = 1'b0; hq();
        scl_m = 1'b1; hq();
        sda_m = 1'b1; hq();
    endtask

    task automatic send_byte(input logic [7:0] b, output logic ack);
        for (int i = 7; i >= 0; i--) begin
            sda_m = b[i]; hq();
            scl_m = 1'b1; hq(); hq();
            scl_m = 1'b0; hq();
        end
        sda_m = 1'b1; hq();
        scl_m = 1'b1; hq();
        ack = ~sda_line; hq();
        scl_m = 1'b0; hq();
    endtask

    task automatic recv_byte(output logic [7:0] b, input logic m_ack, output logic oe_in_ack);
        for (int i = 7; i >= 0; i--) begin
            sda_m = 1'b1; hq();
            scl_m = 1'b1; hq();
            b[i] = sda_line; hq();
            scl_m = 1'b0; hq();
        end
        sda_m = ~m_ack; hq();
        scl_m = 1'b1; hq();
        oe_in_ack = sda_oe; hq();
        scl_m = 1'b0; hq();
    endtask

    task automatic do_write(input logic [15:0] a, input logic [7:0] d, output logic [3:0] acks);
        bus_start();
        send_byte(8'h64, acks[3]);
        send_byte(a[15:8], acks[2]);
        send_byte(a[7:0], acks[1]);
        send_byte(d, acks[0]);
        bus_stop();
    endtask

    task automatic do_read(input logic [15:0] a, input logic m_ack,
                           output logic [7:0] d, output logic [3:0] acks, output logic oe_ack);
        bus_start();
        send_byte(8'h64, acks[3]);
        send_byte(a[15:8], acks[2]);
        send_byte(a[7:0], acks[1]);
        bus_start();
        send_byte(8'h65, acks[0]);
        recv_byte(d, m_ack, oe_ack);
    endtask

    initial begin
        logic [3:0] acks;
        logic [7:0] d;
        logic       a0;
        logic       oe_ack;
        int         w0;
        int         max_oe;

        repeat (4) @(negedge clk);
        // R1 reset state
        chk("R1 sda_oe", 32'(sda_oe), 0);
        chk("R1 reg_we", 32'(reg_we), 0);
        rst = 1'b0;
        hq();

        for (int v = 0; v < 14; v++) begin
            if (VECS[v].wr) begin
                w0 = wcount;
                do_write(VECS[v].a, VECS[v].d, acks);
                // R3 R5 R6 every byte acknowledged
                chk("R3/R5/R6 write acks", 32'(acks), 32'hF);
                // R5 address order
                chk("R5 reg_addr", 32'(reg_addr), 32'(VECS[v].a));
                // R6 / R9 strobe count
                chk("R6/R9 write count", 32'(wcount - w0),
                    (VECS[v].a[15:1] == 15'd0) ? 0 : 1);
            end else begin
                do_read(VECS[v].a, 1'b0, d, acks, oe_ack);
                bus_stop();
                chk("R7 read acks", 32'(acks), 32'hF);
                // R7 / R9 read data
                chk("R7/R9 read data", 32'(d), 32'(VECS[v].d));
                // R10 released in acknowledge slot
                chk("R10 released at ack", 32'(oe_ack), 0);
            end
        end

        // R4 wrong device address: no ack, no write, nothing driven
        w0 = wcount;
        bus_start();
        send_byte(8'hA0, a0);
        chk("R4 foreign device nack", 32'(a0), 0);
        send_byte(8'h00, a0);
        chk("R4 ignored byte nack", 32'(a0), 0);
        send_byte(8'h13, a0);
        send_byte(8'h77, a0);
        bus_stop();
        chk("R4 no write", 32'(wcount - w0), 0);

        // R8 read with no address since stop
        bus_start();
        send_byte(8'h65, a0);
        chk("R8 read without address nack", 32'(a0), 0);
        bus_stop();

        // R2 repeated start re-targets a write to a new address
        w0 = wcount;
        bus_start();
        send_byte(8'h64, a0);
        send_byte(8'h00, a0);
        send_byte(8'h07, a0);
        bus_start();
        send_byte(8'h64, acks[3]);
        send_byte(8'h12, acks[2]);
        send_byte(8'h09, acks[1]);
        send_byte(8'h5A, acks[0]);
        bus_stop();
        chk("R2 restart acks", 32'(acks), 32'hF);
        chk("R2 restart address", 32'(reg_addr), 32'h1209);
        chk("R2 one write", 32'(wcount - w0), 1);
        do_read(16'h0009, 1'b0, d, acks, oe_ack);
        bus_stop();
        chk("R2 readback", 32'(d), 32'h5A);

        // R2 stop mid transfer: no write, next transfer clean
        w0 = wcount;
        bus_start();
        send_byte(8'h64, a0);
        send_byte(8'h00, a0);
        bus_stop();
        chk("R2 stop abort no write", 32'(wcount - w0), 0);
        chk("R2 idle after stop", 32'(sda_oe), 0);

        // R10 master NACK ends read; later clocks are not driven
        do_read(16'h0013, 1'b0, d, acks, oe_ack);
        chk("R10 read data", 32'(d), 32'hA5);
        max_oe = 0;
        sda_m = 1'b1;
        for (int i = 0; i < 9; i++) begin
            hq(); scl_m = 1'b1;
            hq(); if (sda_oe) max_oe++;
            hq(); scl_m = 1'b0;
            hq(); if (sda_oe) max_oe++;
        end
        chk("R10 silent after nack", 32'(max_oe), 0);
        bus_stop();

        // R10 master ACK: still released after one byte
        do_read(16'h0005, 1'b1, d, acks, oe_ack);
        chk("R10 read data ack", 32'(d), 32'h3C);
        max_oe = 0;
        for (int i = 0; i < 9; i++) begin
            sda_m = 1'b1; hq(); scl_m = 1'b1;
            hq(); if (sda_oe) max_oe++;
            hq(); scl_m = 1'b0;
            hq();
        end
        chk("R10 silent after master ack", 32'(max_oe), 0);
        bus_stop();

        // R11 pull-low only starts with SCL low
        chk("R11 oe rise while scl high", 32'(oe_viol), 0);

        done = 1'b1;
        $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end
endmodule